// File: doc/BRIEF.md
# Processor Interrupt Entry Controller

This block decides, cycle by cycle, whether a pipelined processor core takes its single external interrupt request, and it drives the side effects of taking one. When the interrupt is accepted, the instruction in decode is squashed and replaced by a branch to the interrupt vector. The decode-stage PC is written to general-purpose register 14 as the return address. The block also asks the status register to drop its interrupt-enable bit. The instruction in execute is left alone and completes.

The request input is read in one of two ways, chosen by a parameter. In level mode the line is taken whenever it is high and acceptance is allowed. In edge mode a rising edge is captured in a pending latch, whatever the interrupt-enable bit is, and the latch is served on the first cycle in which acceptance is allowed. The vector is either a fixed base address plus 0x10, or an address supplied by an external interrupt controller when the low-latency strap is set. A return-from-interrupt strobe asks for interrupt-enable to be set again.

Top module: `irq_entry_ctrl`

## Requirements
- R1: An interrupt is accepted only in a cycle where ieBit=1, bipBit=0, eipBit=0 and decValid=1. In any other cycle nothing is taken and the request stays outstanding.
- R2: In the cycle of acceptance, replaceDecode, rfWrEn and ieClr are all 1 together, combinationally from the same inputs.
- R3: With lowLatMode=0, branchTarget on acceptance equals BASE_VEC + 0x10.
- R4: With lowLatMode=1, branchTarget on acceptance equals ctrlVec.
- R5: On acceptance rfWrData equals decPc of that cycle, and rfWrIdx is 14.
- R6: rtidDone=1 in a cycle without acceptance gives ieSet=1 in that cycle. Otherwise ieSet is 0.
- R7: Level mode (EDGE_TRIG=0): every cycle in which irqReq=1 and R1 allows acceptance is a take, so a line held high is taken again.
- R8: Edge mode: a one-cycle high pulse is enough to raise a request. A line held high produces one take only, and it must go low for a cycle before it can raise another.
- R9: Edge mode: an edge seen while acceptance is blocked (including ieBit=0) is latched. It is taken on the first cycle that R1 allows.
- R10: After reset the pending latch and the previous-level register are 0. So irqReq=1 in the first cycle after reset counts as an edge.
- R11: When rtidDone=1 falls in a cycle of acceptance, ieClr=1 and ieSet=0.
- R12: Edge mode: a new edge arriving in the same cycle as a take of a latched request merges with it. The pending latch is empty afterwards, and no second take follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqReq | input | 1 | External interrupt request line |
| ieBit | input | 1 | Interrupt-enable status bit |
| bipBit | input | 1 | Break-in-progress status bit |
| eipBit | input | 1 | Exception-in-progress status bit |
| decValid | input | 1 | Decode stage holds a valid instruction |
| decPc | input | ADDR_W | PC of the decode-stage instruction |
| rtidDone | input | 1 | Return-from-interrupt executed this cycle |
| lowLatMode | input | 1 | 1: use controller vector; 0: fixed vector |
| ctrlVec | input | ADDR_W | Vector address from interrupt controller |
| replaceDecode | output | 1 | Squash decode and branch to branchTarget |
| branchTarget | output | ADDR_W | Interrupt vector address |
| rfWrEn | output | 1 | Register file write enable for return address |
| rfWrIdx | output | 5 | Destination register index (14) |
| rfWrData | output | ADDR_W | Return address |
| ieSet | output | 1 | Set interrupt-enable |
| ieClr | output | 1 | Clear interrupt-enable |

## Verification
Two of this block's functions can land in the same cycle: a take that clears interrupt-enable and a return-from-interrupt that sets it. A second clash is a fresh edge that arrives while a latched request is being served. The bench drives rtidDone high in a take cycle and expects ieClr to win with ieSet low. It also latches an edge under ieBit=0, then raises the line again in the cycle ieBit returns. It expects exactly one take, and no take in the following cycle. A reference model in the bench predicts each cycle's outputs for an edge instance and a level instance. The scoreboard compares both.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  // Strobes passed from control to datapath in the acceptance cycle
  typedef struct packed {
    logic take;        // interrupt accepted this cycle
    logic useCtrlVec;  // select controller-supplied vector
  } entryStrobe_t;
endpackage

// File: rtl/irq_entry_ctl.sv
module irq_entry_ctl
  import irq_entry_pkg::*;
#(
  parameter bit EDGE_TRIG = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         irqIn,
  input  logic         ieBit,
  input  logic         bipBit,
  input  logic         eipBit,
  input  logic         decValid,
  input  logic         rtidDone,
  input  logic         lowLatMode,
  output entryStrobe_t strobe,
  output logic         ieSet,
  output logic         ieClr
);
  logic acceptOk;
  logic reqLive;
  logic takeNow;

  assign acceptOk = ieBit & ~bipBit & ~eipBit & decValid;

  generate
    if (EDGE_TRIG) begin : g_edge
      logic prevLvl;
      logic pending;
      logic riseSeen;

      assign riseSeen = irqIn & ~prevLvl;
      assign reqLive  = pending | riseSeen;

      always_ff @(posedge clk) begin
        if (!rstN) begin
          prevLvl <= 1'b0;
          pending <= 1'b0;
        end else begin
          prevLvl <= irqIn;
          pending <= takeNow ? 1'b0 : reqLive;
        end
      end

      // R9: an edge under disabled interrupts is held for later
      a_r9_edge_latched: assert property (@(posedge clk) disable iff (!rstN)
        (!ieBit && irqIn && !prevLvl) |=> pending);
      // R12: a take always leaves the latch empty
      a_r12_pend_cleared: assert property (@(posedge clk) disable iff (!rstN)
        takeNow |=> !pending);
    end else begin : g_level
      assign reqLive = irqIn;
      // R7: a held line is serviced whenever acceptance is allowed
      a_r7_level_take: assert property (@(posedge clk) disable iff (!rstN)
        (irqIn && acceptOk) |-> strobe.take);
    end
  endgenerate

  assign takeNow           = reqLive & acceptOk;
  assign strobe.take       = takeNow;
  assign strobe.useCtrlVec = lowLatMode;
  assign ieClr             = takeNow;
  assign ieSet             = rtidDone & ~takeNow;

  // R11: enable is never set and cleared together
  a_r11_ie_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(ieSet && ieClr));
endmodule

// File: rtl/irq_entry_dp.sv
module irq_entry_dp
  import irq_entry_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter logic [31:0] BASE_VEC  = 32'h0,
  parameter int          RET_REG   = 14,
  parameter int          REG_IDX_W = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  entryStrobe_t         strobe,
  input  logic [ADDR_W-1:0]    decPc,
  input  logic [ADDR_W-1:0]    ctrlVec,
  output logic [ADDR_W-1:0]    branchTarget,
  output logic                 rfWrEn,
  output logic [REG_IDX_W-1:0] rfWrIdx,
  output logic [ADDR_W-1:0]    rfWrData
);
  localparam logic [ADDR_W-1:0] FIXED_VEC = ADDR_W'(BASE_VEC) + ADDR_W'(16);

  always_comb begin
    branchTarget = strobe.useCtrlVec ? ctrlVec : FIXED_VEC;
  end

  assign rfWrEn   = strobe.take;
  assign rfWrIdx  = REG_IDX_W'(RET_REG);
  assign rfWrData = decPc;

  // R3: fixed vector path
  a_r3_fixed_vec: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.take && !strobe.useCtrlVec) |-> branchTarget == FIXED_VEC);
  // R4: controller vector path
  a_r4_ctrl_vec: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.take && strobe.useCtrlVec) |-> branchTarget == ctrlVec);
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_entry_pkg::*;
#(
  parameter bit          EDGE_TRIG = 1'b1,
  parameter int          ADDR_W    = 32,
  parameter logic [31:0] BASE_VEC  = 32'h0000_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              irqReq,
  input  logic              ieBit,
  input  logic              bipBit,
  input  logic              eipBit,
  input  logic              decValid,
  input  logic [ADDR_W-1:0] decPc,
  input  logic              rtidDone,
  input  logic              lowLatMode,
  input  logic [ADDR_W-1:0] ctrlVec,
  output logic              replaceDecode,
  output logic [ADDR_W-1:0] branchTarget,
  output logic              rfWrEn,
  output logic [4:0]        rfWrIdx,
  output logic [ADDR_W-1:0] rfWrData,
  output logic              ieSet,
  output logic              ieClr
);
  entryStrobe_t strobe;

  irq_entry_ctl #(.EDGE_TRIG(EDGE_TRIG)) u_ctl (
    .clk(clk), .rstN(rstN), .irqIn(irqReq), .ieBit(ieBit),
    .bipBit(bipBit), .eipBit(eipBit), .decValid(decValid),
    .rtidDone(rtidDone), .lowLatMode(lowLatMode),
    .strobe(strobe), .ieSet(ieSet), .ieClr(ieClr)
  );

  irq_entry_dp #(.ADDR_W(ADDR_W), .BASE_VEC(BASE_VEC), .RET_REG(14), .REG_IDX_W(5)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .decPc(decPc), .ctrlVec(ctrlVec),
    .branchTarget(branchTarget), .rfWrEn(rfWrEn), .rfWrIdx(rfWrIdx),
    .rfWrData(rfWrData)
  );

  assign replaceDecode = strobe.take;

  // R1: no take unless every status condition allows it
  a_r1_accept_gate: assert property (@(posedge clk) disable iff (!rstN)
    replaceDecode |-> (ieBit && !bipBit && !eipBit && decValid));
  // R2: the side effects travel with the replace request
  a_r2_side_effects: assert property (@(posedge clk) disable iff (!rstN)
    replaceDecode |-> (rfWrEn && ieClr));
  // R5: return address is the decode PC
  a_r5_ret_addr: assert property (@(posedge clk) disable iff (!rstN)
    rfWrEn |-> rfWrData == decPc);
endmodule

// File: tb/test_irq_entry_ctrl.sv
module test_irq_entry_ctrl;
  localparam int          AW   = 32;
  localparam logic [31:0] BASE = 32'h0000_4000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic irqReq = 0, ieBit = 0, bipBit = 0, eipBit = 0, decValid = 0;
  logic rtidDone = 0, lowLatMode = 0;
  logic [AW-1:0] decPc = '0, ctrlVec = 32'h0000_9A40;

  logic replaceDecode, rfWrEn, ieSet, ieClr;
  logic [AW-1:0] branchTarget, rfWrData;
  logic [4:0] rfWrIdx;
  logic lReplace, lRfWrEn, lIeSet, lIeClr;
  logic [AW-1:0] lTarget, lRfData;
  logic [4:0] lRfIdx;

  always #4 clk = ~clk;  // 125 MHz

  irq_entry_ctrl #(.EDGE_TRIG(1'b1), .ADDR_W(AW), .BASE_VEC(BASE)) i_irq_entry_ctrl (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .ieBit(ieBit), .bipBit(bipBit),
    .eipBit(eipBit), .decValid(decValid), .decPc(decPc), .rtidDone(rtidDone),
    .lowLatMode(lowLatMode), .ctrlVec(ctrlVec), .replaceDecode(replaceDecode),
    .branchTarget(branchTarget), .rfWrEn(rfWrEn), .rfWrIdx(rfWrIdx),
    .rfWrData(rfWrData), .ieSet(ieSet), .ieClr(ieClr)
  );

  irq_entry_ctrl #(.EDGE_TRIG(1'b0), .ADDR_W(AW), .BASE_VEC(BASE)) i_irq_entry_ctrl_lvl (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .ieBit(ieBit), .bipBit(bipBit),
    .eipBit(eipBit), .decValid(decValid), .decPc(decPc), .rtidDone(rtidDone),
    .lowLatMode(lowLatMode), .ctrlVec(ctrlVec), .replaceDecode(lReplace),
    .branchTarget(lTarget), .rfWrEn(lRfWrEn), .rfWrIdx(lRfIdx),
    .rfWrData(lRfData), .ieSet(lIeSet), .ieClr(lIeClr)
  );

  typedef struct {
    string       tag;
    logic        take;
    logic        lvlTake;
    logic        setE;
    logic [AW-1:0] target;
    logic [AW-1:0] pc;
  } expItem_t;

  expItem_t scoreQ[$];
  int checks = 0;
  int errors = 0;
  logic mPrev = 0, mPend = 0;
  bit done = 0;

  task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: compare outputs mid low phase against queued expectations
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (scoreQ.size() > 0) begin
        expItem_t e;
        e = scoreQ.pop_front();
        check({e.tag, " replace"}, AW'(replaceDecode), AW'(e.take));
        check({e.tag, " rfWrEn"},  AW'(rfWrEn),        AW'(e.take));
        check({e.tag, " ieClr"},   AW'(ieClr),         AW'(e.take));
        check({e.tag, " ieSet"},   AW'(ieSet),         AW'(e.setE));
        check({e.tag, " level replace"}, AW'(lReplace), AW'(e.lvlTake));
        if (e.take) begin
          check({e.tag, " target"}, branchTarget, e.target);
          check({e.tag, " retaddr"}, rfWrData, e.pc);
          check({e.tag, " R5 index"}, AW'(rfWrIdx), AW'(14));
        end
      end
    end
  end

  // Driver: apply one cycle of inputs and push the predicted result
  task automatic cyc(input logic irq, input logic ie, input logic bip, input logic eip,
                     input logic dv, input logic rtid, input logic ll, input string tag);
    expItem_t e;
    logic ok, req, tk;
    @(negedge clk);
    irqReq = irq; ieBit = ie; bipBit = bip; eipBit = eip; decValid = dv;
    rtidDone = rtid; lowLatMode = ll; decPc = decPc + 32'h4;
    ok  = ie & ~bip & ~eip & dv;
    req = mPend | (irq & ~mPrev);
    tk  = req & ok;
    e.tag = tag; e.take = tk; e.lvlTake = irq & ok; e.setE = rtid & ~tk;
    e.target = ll ? ctrlVec : BASE + 32'h10;
    e.pc = decPc;
    scoreQ.push_back(e);
    mPend = tk ? 1'b0 : req;
    mPrev = irq;
  endtask

  task automatic doReset(input logic irqHeld);
    @(negedge clk);
    rstN = 0; irqReq = irqHeld; ieBit = 0; rtidDone = 0; decValid = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    mPrev = 0; mPend = 0;
  endtask

  task automatic finishRun();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    doReset(1'b0);
    cyc(0,1,0,0,1,0,0,"R10 idle after reset");
    cyc(1,1,0,0,1,0,0,"R2 R3 R5 edge take");
    cyc(1,1,0,0,1,0,0,"R8 held no retake / R7 level retake");
    cyc(1,1,0,0,1,0,0,"R8 still held / R7 level again");
    cyc(0,1,0,0,1,0,0,"R8 line low");
    cyc(1,0,0,0,1,0,0,"R9 edge while disabled");
    cyc(0,0,0,0,1,0,0,"R9 still pending");
    cyc(0,0,0,0,1,0,0,"R9 still pending 2");
    cyc(0,1,0,0,1,0,0,"R9 served on enable");
    cyc(0,1,0,0,1,0,0,"R9 served once");
    cyc(1,1,1,0,1,0,0,"R1 blocked by break");
    cyc(0,1,0,1,1,0,0,"R1 blocked by exception");
    cyc(0,1,0,0,0,0,0,"R1 blocked by empty decode");
    cyc(0,1,0,0,1,0,1,"R4 controller vector");
    cyc(0,1,0,0,1,1,0,"R6 rtid alone");
    cyc(1,1,0,0,1,1,0,"R11 rtid with take");
    cyc(0,1,0,0,1,0,0,"R11 gap");
    cyc(1,0,0,0,1,0,0,"R12 latch edge");
    cyc(0,0,0,0,1,0,0,"R12 gap");
    cyc(1,1,0,0,1,0,1,"R12 new edge at take");
    cyc(0,1,0,0,1,0,0,"R12 no second take");
    cyc(1,1,0,0,1,0,0,"R7 R8 pulse");
    doReset(1'b1);
    cyc(1,1,0,0,1,0,0,"R10 high after reset is edge");
    cyc(1,1,0,0,1,0,0,"R10 held after reset");
    finishRun();
  end
endmodule